// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Arbiter

This block holds a bank of token flags that two independent agents, a left port and a right port, use to agree on who owns a shared resource. Each port has its own synchronous access path with a select, a write enable, a token index, one bit of write data and one bit of read data.

A port claims a token by writing a zero to it, and gives it up or withdraws its claim by writing a one. Reading a token returns zero while that port owns it and one otherwise. Each side keeps one request latch per token. Grant logic makes sure that a token never has two owners.

A request that loses stays latched. The token passes to that waiting side on the same clock edge that records the owner's release. When both sides claim a free token in the same cycle, the left port wins. A token is never released by the block itself: only a write of one from its owner frees it.

Top module: `dp_sem_arbiter`

## Requirements
- R1: While reset is asserted, every request latch on both sides returns to the released state. After reset, every token reads one from both ports.
- R2: A write of zero from a port to a free token grants that token to the port. From the next cycle on, that port reads zero from that index.
- R3: While one port owns a token, the other port reads one from that index. This holds even after the other port has written a zero to it, which leaves its request latched as pending.
- R4: At no time do both ports read zero from the same index.
- R5: When the two ports write zero to the same token in different cycles, the one that wrote first is granted, and the later one reads one.
- R6: When both ports write zero to the same free token in the same cycle, the left port is granted. From the next cycle the left port reads zero and the right port reads one.
- R7: When the owner writes one while the other side has a pending request, the waiting side is granted at that same clock edge. From the next cycle the waiting side reads zero and the former owner reads one.
- R8: A pending request that is withdrawn by a write of one is not granted later. When the owner then releases, the token is free and both ports read one.
- R9: A token stays with its owner for as long as the owner writes no one to it, whatever the other port does meanwhile.
- R10: The tokens are independent. Claiming or releasing one index changes the value read from no other index.
- R11: Read data shows the grant state registered at the previous clock edge. In a cycle where a port writes an index, the value read from that index is the state before the write.
- R12: Writing one to every index from both ports leaves every token free, whatever the earlier state was.
- R13: A port with its select low has no effect on any token, and its read data is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lft_sel | input | 1 | Left port select |
| lft_wr | input | 1 | Left port write enable (1 write, 0 read) |
| lft_idx | input | IDX_W | Left port token index |
| lft_wbit | input | 1 | Left write data: 0 claims, 1 releases or withdraws |
| lft_rbit | output | 1 | Left read data: 0 owned by left, 1 otherwise |
| rgt_sel | input | 1 | Right port select |
| rgt_wr | input | 1 | Right port write enable (1 write, 0 read) |
| rgt_idx | input | IDX_W | Right port token index |
| rgt_wbit | input | 1 | Right write data: 0 claims, 1 releases or withdraws |
| rgt_rbit | output | 1 | Right read data: 0 owned by right, 1 otherwise |

## Verification
The bench builds the block with the default of eight tokens. With that setting the full 3-bit index range is in use, and the bench can hold several tokens at once in a mix of left-owned, right-owned and pending states before it writes one to all of them. The depth is small, so the bench can read back every index after a mass release or a reset. It also exercises same-cycle contention, pending hand-over, withdrawal and a long hold on separate indices.

// File: rtl/dp_sem_pkg.sv
package dp_sem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } sem_owner_t;

endpackage

// File: rtl/dp_sem_rst_sync.sv
module dp_sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dp_sem_port.sv
module dp_sem_port #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3
) (
  input  logic               sel,
  input  logic               wr,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wbit,
  input  logic [NUM_SEM-1:0] gnt_vec,
  output logic [NUM_SEM-1:0] claim_vec,
  output logic [NUM_SEM-1:0] drop_vec,
  output logic               rbit
);

  logic wr_act;
  assign wr_act = sel & wr;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    logic hit;
    assign hit          = wr_act && (idx == IDX_W'(g));
    assign claim_vec[g] = hit & ~wbit;
    assign drop_vec[g]  = hit &  wbit;
  end

  always_comb begin
    rbit = 1'b1;
    if (sel) rbit = ~gnt_vec[idx];
  end

endmodule

// File: rtl/dp_sem_cell.sv
module dp_sem_cell
  import dp_sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic claim_l,
  input  logic drop_l,
  input  logic claim_r,
  input  logic drop_r,
  output logic gnt_l,
  output logic gnt_r
);

  logic       pend_l_q, pend_r_q;
  logic       pend_l_d, pend_r_d;
  logic       pend_en;
  sem_owner_t own_q, own_d;

  // request latch next state
  always_comb begin
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    if (claim_l) pend_l_d = 1'b1;
    if (drop_l)  pend_l_d = 1'b0;
    if (claim_r) pend_r_d = 1'b1;
    if (drop_r)  pend_r_d = 1'b0;
  end

  assign pend_en = claim_l | drop_l | claim_r | drop_r;

  // owner next state from the updated request latches
  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_LEFT: begin
        if (!pend_l_d) own_d = pend_r_d ? OWN_RIGHT : OWN_NONE;
      end
      OWN_RIGHT: begin
        if (!pend_r_d) own_d = pend_l_d ? OWN_LEFT : OWN_NONE;
      end
      default: begin
        if (pend_l_d)      own_d = OWN_LEFT;
        else if (pend_r_d) own_d = OWN_RIGHT;
        else               own_d = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
      own_q    <= OWN_NONE;
    end else if (pend_en) begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      own_q    <= own_d;
    end
  end

  assign gnt_l = (own_q == OWN_LEFT);
  assign gnt_r = (own_q == OWN_RIGHT);

  // R2
  owner_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT) |-> pend_l_q);

  // R9
  hold_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT && !drop_l) |=> (own_q == OWN_LEFT));

  // R9
  hold_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_RIGHT && !drop_r) |=> (own_q == OWN_RIGHT));

  // R6
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_NONE && claim_l && claim_r) |=> (own_q == OWN_LEFT));

  // R7
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT && drop_l && pend_r_q && !drop_r) |=> (own_q == OWN_RIGHT));

endmodule

// File: rtl/dp_sem_arbiter.sv
module dp_sem_arbiter #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lft_sel,
  input  logic             lft_wr,
  input  logic [IDX_W-1:0] lft_idx,
  input  logic             lft_wbit,
  output logic             lft_rbit,
  input  logic             rgt_sel,
  input  logic             rgt_wr,
  input  logic [IDX_W-1:0] rgt_idx,
  input  logic             rgt_wbit,
  output logic             rgt_rbit
);

  logic               rst_sync_n;
  logic [NUM_SEM-1:0] claim_l, drop_l, claim_r, drop_r;
  logic [NUM_SEM-1:0] gnt_l, gnt_r;

  dp_sem_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  dp_sem_port #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_lft (
    .sel      (lft_sel),
    .wr       (lft_wr),
    .idx      (lft_idx),
    .wbit     (lft_wbit),
    .gnt_vec  (gnt_l),
    .claim_vec(claim_l),
    .drop_vec (drop_l),
    .rbit     (lft_rbit)
  );

  dp_sem_port #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rgt (
    .sel      (rgt_sel),
    .wr       (rgt_wr),
    .idx      (rgt_idx),
    .wbit     (rgt_wbit),
    .gnt_vec  (gnt_r),
    .claim_vec(claim_r),
    .drop_vec (drop_r),
    .rbit     (rgt_rbit)
  );

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    dp_sem_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .claim_l(claim_l[s]),
      .drop_l (drop_l[s]),
      .claim_r(claim_r[s]),
      .drop_r (drop_r[s]),
      .gnt_l  (gnt_l[s]),
      .gnt_r  (gnt_r[s])
    );
  end

  // R4
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lft_sel && rgt_sel && lft_idx == rgt_idx) |-> (lft_rbit || rgt_rbit));

  // R13
  idle_left_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lft_sel) |=> $stable(gnt_l) && $stable(gnt_r) || $past(rgt_sel && rgt_wr));

endmodule

// File: tb/dp_sem_arbiter_tb_top.sv
module dp_sem_arbiter_tb_top;

  localparam int NS = 8;
  localparam int IW = 3;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lsel, lwr, lwb, rsel, rwr, rwb;
  logic [IW-1:0] lidx, ridx;
  logic          lrb, rrb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dp_sem_arbiter #(.NUM_SEM(NS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lft_sel(lsel), .lft_wr(lwr), .lft_idx(lidx), .lft_wbit(lwb), .lft_rbit(lrb),
    .rgt_sel(rsel), .rgt_wr(rwr), .rgt_idx(ridx), .rgt_wbit(rwb), .rgt_rbit(rrb)
  );

  // {lsel,lwr,lidx,lwb, rsel,rwr,ridx,rwb, exp_l, exp_r}; exp = read data before the edge
  localparam logic [13:0] VEC [NV] = '{
    14'b1_0_000_0_1_0_000_0_1_1,  // R1 free after reset
    14'b1_1_000_0_1_0_000_0_1_1,  // R11 left claims 0, reads old state
    14'b1_0_000_0_1_0_000_0_0_1,  // R2 left owns 0
    14'b1_0_000_0_1_1_000_0_0_1,  // R3 right claims owned token
    14'b1_0_000_0_1_0_000_0_0_1,  // R3 right denied, pending
    14'b1_1_000_1_1_0_000_0_0_1,  // R11 left releases, reads old state
    14'b1_0_000_0_1_0_000_0_1_0,  // R7 right got it
    14'b1_0_000_0_1_1_000_1_1_0,  // R7 right releases
    14'b1_0_000_0_1_0_000_0_1_1,  // R7 token free
    14'b1_1_001_0_1_1_001_0_1_1,  // R6 tie on 1
    14'b1_0_001_0_1_0_001_0_0_1,  // R6 left wins
    14'b1_0_001_0_1_1_001_1_0_1,  // R8 right withdraws
    14'b1_1_001_1_1_0_001_0_0_1,  // R8 left releases
    14'b1_0_001_0_1_0_001_0_1_1,  // R8 nobody holds 1
    14'b1_0_010_0_1_1_010_0_1_1,  // R5 right claims 2 first
    14'b1_1_010_0_1_0_010_0_1_0,  // R5 left claims later
    14'b1_0_010_0_1_0_010_0_1_0,  // R5 right keeps it
    14'b1_0_011_0_1_0_011_0_1_1,  // R10 idx 3 untouched
    14'b0_1_011_0_1_0_011_0_1_1,  // R13 deselected write
    14'b1_0_011_0_1_0_011_0_1_1   // R13 no effect
  };

  string VTAG [NV] = '{"R1","R11","R2","R3","R3","R11","R7","R7","R7","R6",
                       "R6","R8","R8","R8","R5","R5","R5","R10","R13","R13"};

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic ls, input logic lw, input logic [IW-1:0] li, input logic lb,
                       input logic rs, input logic rw, input logic [IW-1:0] ri, input logic rb);
    lsel = ls; lwr = lw; lidx = li; lwb = lb;
    rsel = rs; rwr = rw; ridx = ri; rwb = rb;
  endtask

  // R4 checked on every sampled cycle with a shared index
  task automatic excl_chk();
    if (lsel && rsel && lidx == ridx) begin
      checks++;
      if (!lrb && !rrb) begin
        errors++;
        $display("FAIL R4 both own idx %0d actual 00 expected not 00", lidx);
      end
    end
  endtask

  task automatic cyc(input logic ls, input logic lw, input logic [IW-1:0] li, input logic lb,
                     input logic rs, input logic rw, input logic [IW-1:0] ri, input logic rb);
    @(negedge clk);
    drive(ls, lw, li, lb, rs, rw, ri, rb);
    #1;
    excl_chk();
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, '0, 1, 0, 0, '0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[13], v[12], v[11:9], v[8], v[7], v[6], v[5:3], v[2]);
      #1;
      chk(lrb, v[1], VTAG[i], $sformatf("vec %0d left", i));
      chk(rrb, v[0], VTAG[i], $sformatf("vec %0d right", i));
      excl_chk();
    end

    // R9: right holds 2 while left keeps claiming and releasing it for many cycles
    for (int k = 0; k < 60; k++)
      cyc(1, 1, 3'd2, 1'(k % 2), 1, 0, 3'd2, 0);
    cyc(1, 0, 3'd2, 0, 1, 0, 3'd2, 0);
    chk(rrb, 1'b0, "R9", "right still owns 2");
    chk(lrb, 1'b1, "R9", "left still denied 2");

    // R12: fill a mix of states, then release all from both sides
    cyc(1, 1, 3'd4, 0, 1, 1, 3'd6, 0);
    cyc(1, 1, 3'd5, 0, 1, 1, 3'd7, 0);
    cyc(1, 1, 3'd6, 0, 1, 1, 3'd4, 0);
    cyc(1, 0, 3'd4, 0, 1, 0, 3'd6, 0);
    chk(lrb, 1'b0, "R10", "left owns 4");
    chk(rrb, 1'b0, "R10", "right owns 6");
    for (int s = 0; s < NS; s++)
      cyc(1, 1, IW'(s), 1, 1, 1, IW'(s), 1);
    for (int s = 0; s < NS; s++) begin
      cyc(1, 0, IW'(s), 0, 1, 0, IW'(s), 0);
      chk(lrb, 1'b1, "R12", $sformatf("left idx %0d", s));
      chk(rrb, 1'b1, "R12", $sformatf("right idx %0d", s));
    end

    // R13: deselected port reads one even while it owns the token
    cyc(1, 1, 3'd3, 0, 0, 0, 3'd0, 1);
    cyc(0, 0, 3'd3, 0, 1, 0, 3'd3, 0);
    chk(lrb, 1'b1, "R13", "deselected left read");
    cyc(1, 0, 3'd3, 0, 1, 1, 3'd5, 0);
    chk(lrb, 1'b0, "R13", "left owns 3");

    // R1: reset mid-run clears owned and pending tokens
    @(negedge clk);
    rst_n = 1'b0;
    drive(0, 0, '0, 1, 0, 0, '0, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      cyc(1, 0, IW'(s), 0, 1, 0, IW'(s), 0);
      chk(lrb, 1'b1, "R1", $sformatf("left idx %0d after reset", s));
      chk(rrb, 1'b1, "R1", $sformatf("right idx %0d after reset", s));
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule